// File: doc/BRIEF.md
# Power-Management Event Status and SCI Controller

This block keeps the power-management event state of a chipset: a status register that records wake and alarm events, an enable register that selects which of them may interrupt, a plain control register, and a free-running timer. All of them are reached through a 64-byte I/O window. The window's base address and its on/off switch come from configuration inputs, so the window can be moved anywhere on a 64-byte boundary in a 16-bit I/O space.

The block drives one level-sensitive system-control interrupt (SCI). The interrupt stays high while any of four sources has both its status and its enable bit set. The four sources are the real-time-clock alarm, the power button, the global-lock release and the timer. Three sources are external inputs that set their status bit on a rising edge, after an optional synchroniser. The timer source sets its status bit when the most significant bit of the counter toggles, but only while the timer event is armed. Software clears a status bit by writing a one to it.

Accesses are 16-bit and word-aligned. A write takes effect at the clock edge where `io_wr` is sampled high. Read data is combinational from the current register state and the address.

Top module: `pm_event_sci`

## Requirements
- R1: After reset the status, enable and control registers are zero, `sci` is low, the timer counts from zero, and `io_rdata` is zero while the window is disabled.
- R2: The window decodes only while `cfg_win_en` is high. It covers addresses `cfg_base[15:0] & 16'hFFC0` through that value plus 63. Outside the window, or while it is disabled, `io_rdata` is 0 and writes change no register.
- R3: Register map by window offset: status at 0x00, enable at 0x02, control at 0x04, timer bits [15:0] at 0x08 and timer bits above 15 at 0x0A. Any other offset reads 0. Only enable bits 0, 5, 8 and 10 are writable; the other enable bits read 0. All 16 control bits read back as written.
- R4: Writing status with a 1 in a bit position clears that bit. A 0 leaves the bit unchanged.
- R5: A rising edge on `evt_rtc` sets status bit 10, on `evt_pwrbtn` bit 8, and on `evt_gbl` bit 5. A level held high does not set the bit again after software clears it.
- R6: `sci` is high exactly when (status AND enable AND 16'h0521) is nonzero, with no added latency after a register change.
- R7: The timer increments by one every clock and wraps at 2^TMR_W. Writes to offsets 0x08 and 0x0A are ignored.
- R8: Status bit 0 sets when bit TMR_W-1 of the timer toggles, and only while enable bit 0 is set and status bit 0 is clear. With enable bit 0 clear, timer wraps never set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Configuration word holding the window base; only bits 15:6 are used |
| cfg_win_en | input | 1 | Window decode enable |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data for `io_addr`; zero on a miss |
| evt_rtc | input | 1 | Real-time-clock alarm event |
| evt_pwrbtn | input | 1 | Power-button event |
| evt_gbl | input | 1 | Global-lock release event |
| sci | output | 1 | Level-sensitive system-control interrupt |

## Verification
The hardest state to reach from the ports is a timer-overflow status. It depends on when the counter's top bit flips, and that moment is not under the stimulus's control. The bench therefore uses a 6-bit timer, so a toggle comes every 32 cycles. Each wait spans more than two toggles, and the outcome is then checked with the arm condition both on and off. Interrupt generation is swept over every combination of the three external event patterns and the sixteen enable patterns. The expected SCI level is computed from the status word read back in the same sample.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
   localparam int REG_W   = 16;
   localparam int BIT_TMR = 0;
   localparam int BIT_GBL = 5;
   localparam int BIT_PWR = 8;
   localparam int BIT_RTC = 10;
   localparam logic [REG_W-1:0] EVT_MASK =
      (REG_W'(1) << BIT_TMR) | (REG_W'(1) << BIT_GBL) |
      (REG_W'(1) << BIT_PWR) | (REG_W'(1) << BIT_RTC);
   localparam logic [5:0] OFS_STS = 6'h00;
   localparam logic [5:0] OFS_EN  = 6'h02;
   localparam logic [5:0] OFS_CTL = 6'h04;
   localparam logic [5:0] OFS_TLO = 6'h08;
   localparam logic [5:0] OFS_THI = 6'h0A;
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
   parameter int ADDR_W   = 16,
   parameter int WIN_LOG2 = 6
) (
   input  logic [31:0]         cfg_base,
   input  logic                win_en,
   input  logic [ADDR_W-1:0]   addr,
   output logic                hit,
   output logic [WIN_LOG2-1:0] offset
);
   // Base bits below the window size are dropped, so the window is aligned
   assign hit    = win_en && (addr[ADDR_W-1:WIN_LOG2] == cfg_base[ADDR_W-1:WIN_LOG2]);
   assign offset = addr[WIN_LOG2-1:0];
endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
   parameter int TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TMR_W-1:0] count,
   output logic             msb_toggle
);
   logic msb_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count      <= '0;
         msb_prev_q <= 1'b0;
      end else begin
         count      <= count + 1'b1;
         msb_prev_q <= count[TMR_W-1];
      end
   end

   assign msb_toggle = count[TMR_W-1] ^ msb_prev_q;
endmodule

// File: rtl/pm_edge_detect.sv
module pm_edge_detect #(
   parameter int N           = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] rise
);
   logic [N-1:0] level;
   logic [N-1:0] prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign level = din;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][N-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else begin
               chain_q[0] <= din;
               for (int s = 1; s < SYNC_STAGES; s++) chain_q[s] <= chain_q[s-1];
            end
         end
         assign level = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
   import pm_evt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sts_wr,
   input  logic             en_wr,
   input  logic             ctl_wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             rise_rtc,
   input  logic             rise_pwr,
   input  logic             rise_gbl,
   input  logic             tmr_toggle,
   output logic [REG_W-1:0] sts,
   output logic [REG_W-1:0] en,
   output logic [REG_W-1:0] ctl,
   output logic             sci
);
   logic             tmr_armed;
   logic [REG_W-1:0] set_vec;
   logic [REG_W-1:0] clr_vec;

   assign tmr_armed = en[BIT_TMR] && !sts[BIT_TMR];

   always_comb begin
      set_vec          = '0;
      set_vec[BIT_RTC] = rise_rtc;
      set_vec[BIT_PWR] = rise_pwr;
      set_vec[BIT_GBL] = rise_gbl;
      set_vec[BIT_TMR] = tmr_toggle && tmr_armed;
      clr_vec          = sts_wr ? (wdata & EVT_MASK) : '0;
   end

   // A new event in the same cycle as a clear wins, so no event is lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts <= '0;
         en  <= '0;
         ctl <= '0;
      end else begin
         sts <= (sts & ~clr_vec) | set_vec;
         if (en_wr)  en  <= wdata & EVT_MASK;
         if (ctl_wr) ctl <= wdata;
      end
   end

   assign sci = |(sts & en & EVT_MASK);
endmodule

// File: rtl/pm_event_sci.sv
module pm_event_sci
   import pm_evt_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int WIN_LOG2    = 6,
   parameter int TMR_W       = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       cfg_base,
   input  logic              cfg_win_en,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic [REG_W-1:0]  io_wdata,
   output logic [REG_W-1:0]  io_rdata,
   input  logic              evt_rtc,
   input  logic              evt_pwrbtn,
   input  logic              evt_gbl,
   output logic              sci
);
   localparam int NUM_EVT = 3;

   generate
      if (TMR_W < 2 || TMR_W > 31) begin : g_bad_tmr
         $error("pm_event_sci: TMR_W must lie in 2..31");
      end
      if (WIN_LOG2 != 6) begin : g_bad_win
         $error("pm_event_sci: register map needs a 64-byte window");
      end
      if (ADDR_W <= WIN_LOG2 || ADDR_W > 32) begin : g_bad_addr
         $error("pm_event_sci: ADDR_W must exceed WIN_LOG2 and fit 32 bits");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("pm_event_sci: SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   logic                hit;
   logic [WIN_LOG2-1:0] offset;
   logic                sts_wr, en_wr, ctl_wr;
   logic [TMR_W-1:0]    tmr_q;
   logic                tmr_toggle;
   logic [NUM_EVT-1:0]  rise;
   logic [REG_W-1:0]    sts_q, en_q, ctrl_q;
   logic [31:0]         tmr_ext;

   pm_win_decode #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_dec (
      .cfg_base(cfg_base), .win_en(cfg_win_en), .addr(io_addr),
      .hit(hit), .offset(offset)
   );

   pm_timer #(.TMR_W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .count(tmr_q), .msb_toggle(tmr_toggle)
   );

   pm_edge_detect #(.N(NUM_EVT), .SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n),
      .din({evt_rtc, evt_pwrbtn, evt_gbl}), .rise(rise)
   );

   assign sts_wr = io_wr && hit && (offset == OFS_STS);
   assign en_wr  = io_wr && hit && (offset == OFS_EN);
   assign ctl_wr = io_wr && hit && (offset == OFS_CTL);

   pm_evt_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .sts_wr(sts_wr), .en_wr(en_wr), .ctl_wr(ctl_wr), .wdata(io_wdata),
      .rise_rtc(rise[2]), .rise_pwr(rise[1]), .rise_gbl(rise[0]),
      .tmr_toggle(tmr_toggle),
      .sts(sts_q), .en(en_q), .ctl(ctrl_q), .sci(sci)
   );

   assign tmr_ext = 32'(tmr_q);

   always_comb begin
      io_rdata = '0;
      if (hit) begin
         case (offset)
            OFS_STS: io_rdata = sts_q;
            OFS_EN:  io_rdata = en_q;
            OFS_CTL: io_rdata = ctrl_q;
            OFS_TLO: io_rdata = tmr_ext[15:0];
            OFS_THI: io_rdata = tmr_ext[31:16];
            default: io_rdata = '0;
         endcase
      end
   end
endmodule

module pm_event_sci_chk #(
   parameter int TMR_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_win_en,
   input logic [15:0]      io_rdata,
   input logic [15:0]      io_wdata,
   input logic             sci,
   input logic [15:0]      sts_q,
   input logic [15:0]      en_q,
   input logic [15:0]      ctrl_q,
   input logic [TMR_W-1:0] tmr_q,
   input logic             sts_wr
);
   assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (sts_q == 16'h0 && en_q == 16'h0 && ctrl_q == 16'h0 && !sci));

   assert_closed_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_win_en |-> (io_rdata == 16'h0));

   assert_closed_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(cfg_win_en)) |-> ($stable(en_q) && $stable(ctrl_q)));

   assert_clear_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (($past(sts_q) & ~sts_q) != 16'h0)) |->
      ($past(sts_wr) && ((($past(sts_q) & ~sts_q) & ~$past(io_wdata)) == 16'h0)));

   assert_sci_needs_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(sci) && sci) |->
      (sts_q != $past(sts_q) || en_q != $past(en_q)));

   assert_timer_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (tmr_q == $past(tmr_q) + 1'b1));

   assert_tmr_sts_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(sts_q[0])) |-> $past(en_q[0]));
endmodule

bind pm_event_sci pm_event_sci_chk #(.TMR_W(TMR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_win_en(cfg_win_en), .io_rdata(io_rdata),
   .io_wdata(io_wdata), .sci(sci), .sts_q(sts_q), .en_q(en_q),
   .ctrl_q(ctrl_q), .tmr_q(tmr_q), .sts_wr(sts_wr)
);

// File: tb/pm_event_sci_test.sv
`timescale 1ns/1ps
module pm_event_sci_test;
   localparam int TW = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_base = 32'h0000_ABCD;
   logic        cfg_win_en = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic [15:0] io_wdata = '0;
   logic [15:0] io_rdata;
   logic        evt_rtc = 1'b0, evt_pwrbtn = 1'b0, evt_gbl = 1'b0;
   logic        sci;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   pm_event_sci #(.TMR_W(TW), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_win_en(cfg_win_en),
      .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .evt_rtc(evt_rtc), .evt_pwrbtn(evt_pwrbtn), .evt_gbl(evt_gbl), .sci(sci)
   );

   localparam logic [15:0] WB = 16'hABC0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [15:0] v);
      @(negedge clk);
      io_addr = a;
      #1 v = io_rdata;
   endtask

   task automatic pulse(input logic [2:0] p);
      @(negedge clk);
      evt_rtc = p[2]; evt_pwrbtn = p[1]; evt_gbl = p[0];
      @(negedge clk);
      evt_rtc = 1'b0; evt_pwrbtn = 1'b0; evt_gbl = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   function automatic logic [15:0] en_map(input logic [3:0] b);
      return (b[0] ? 16'h0001 : 16'h0) | (b[1] ? 16'h0020 : 16'h0) |
             (b[2] ? 16'h0100 : 16'h0) | (b[3] ? 16'h0400 : 16'h0);
   endfunction

   function automatic logic [15:0] ev_map(input logic [2:0] p);
      return (p[2] ? 16'h0400 : 16'h0) | (p[1] ? 16'h0100 : 16'h0) |
             (p[0] ? 16'h0020 : 16'h0);
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [15:0] v, t1, t2, s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      #1;
      chk("R1 sci", {31'b0, sci}, 0);
      chk("R1 rdata closed", {16'b0, io_rdata}, 0);
      cfg_win_en = 1'b1;
      rd(WB + 0, v); chk("R1 status", {16'b0, v}, 0);
      rd(WB + 2, v); chk("R1 enable", {16'b0, v}, 0);
      rd(WB + 4, v); chk("R1 control", {16'b0, v}, 0);

      // R3 enable mask and control read-back
      wr(WB + 2, 16'hFFFF); rd(WB + 2, v); chk("R3 enable mask", {16'b0, v}, 16'h0521);
      wr(WB + 2, 16'h0000);
      wr(WB + 4, 16'hA5C3); rd(WB + 4, v); chk("R3 control rw", {16'b0, v}, 16'hA5C3);
      rd(WB + 6, v);  chk("R3 unmapped offset", {16'b0, v}, 0);
      rd(WB + 10, v); chk("R3 timer high half", {16'b0, v}, 0);

      // R2 window bounds, relocation and disable
      rd(WB + 64, v); chk("R2 past window", {16'b0, v}, 0);
      rd(WB - 2, v);  chk("R2 below window", {16'b0, v}, 0);
      cfg_base = 32'hFFFF_1240;
      rd(16'h1244, v); chk("R2 relocated", {16'b0, v}, 16'hA5C3);
      rd(WB + 4, v);   chk("R2 old base dead", {16'b0, v}, 0);
      wr(WB + 4, 16'h1111);
      rd(16'h1244, v); chk("R2 miss write ignored", {16'b0, v}, 16'hA5C3);
      cfg_win_en = 1'b0;
      wr(16'h1244, 16'h2222);
      rd(16'h1244, v); chk("R2 disabled read", {16'b0, v}, 0);
      cfg_win_en = 1'b1;
      rd(16'h1244, v); chk("R2 disabled write ignored", {16'b0, v}, 16'hA5C3);
      cfg_base = 32'h0000_ABCD;

      // R7 timer counting and read-only
      rd(WB + 8, t1); repeat (9) @(negedge clk); rd(WB + 8, t2);
      chk("R7 timer step", {16'b0, t2}, {16'b0, 10'b0, 6'(t1 + 16'd10)});
      rd(WB + 8, t1); wr(WB + 8, 16'h0000); rd(WB + 8, t2);
      chk("R7 timer write ignored", {16'b0, t2}, {16'b0, 10'b0, 6'(t1 + 16'd3)});

      // R5 / R6 sweep of every event pattern against every enable pattern
      for (int e = 0; e < 16; e++) begin
         for (int p = 0; p < 8; p++) begin
            wr(WB + 2, 16'h0000);
            wr(WB + 0, 16'hFFFF);
            pulse(3'(p));
            wr(WB + 2, en_map(4'(e)));
            rd(WB + 0, s);
            chk("R5 event bits", {16'b0, s & 16'h0520}, {16'b0, ev_map(3'(p))});
            chk("R6 sci level", {31'b0, sci}, {31'b0, |(s & en_map(4'(e)) & 16'h0521)});
         end
      end

      // R4 write-one-to-clear, zero keeps
      wr(WB + 2, 16'h0000); wr(WB + 0, 16'hFFFF);
      pulse(3'b101);
      wr(WB + 0, 16'h0000); rd(WB + 0, s);
      chk("R4 zero keeps", {16'b0, s & 16'h0520}, 16'h0420);
      wr(WB + 0, 16'h0020); rd(WB + 0, s);
      chk("R4 one clears", {16'b0, s & 16'h0520}, 16'h0400);

      // R5 steady level does not re-set
      @(negedge clk); evt_pwrbtn = 1'b1;
      repeat (6) @(negedge clk);
      wr(WB + 0, 16'hFFFF);
      repeat (10) @(negedge clk);
      rd(WB + 0, s); chk("R5 steady level", {16'b0, s & 16'h0100}, 0);
      evt_pwrbtn = 1'b0; repeat (5) @(negedge clk);

      // R8 timer status only while armed
      wr(WB + 2, 16'h0000); wr(WB + 0, 16'hFFFF);
      repeat (80) @(negedge clk);
      rd(WB + 0, s); chk("R8 disarmed no set", {16'b0, s & 16'h0001}, 0);
      wr(WB + 2, 16'h0001);
      repeat (80) @(negedge clk);
      rd(WB + 0, s); chk("R8 armed sets", {16'b0, s & 16'h0001}, 1);
      chk("R8 R6 sci from timer", {31'b0, sci}, 1);
      wr(WB + 0, 16'h0001); #1;
      chk("R4 R6 clear drops sci", {31'b0, sci}, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule